// File: doc/BRIEF.md
# Multiply-Accumulate Custom-Instruction Unit

This unit sits beside a processor core on its multicycle custom-instruction port. It owns a private bank of general registers. Each instruction carries three flags and three register indexes, and these set where the two operands come from and where the answer goes. An operand is either the 32-bit word the processor supplies or the content of a private register. The answer is either returned to the processor or stored in a private register.

The operation is multiply-accumulate. Register 0 holds the running sum. Every instruction computes the sum plus the product of its two operands. An instruction that stores internally writes that value to the register chosen by its destination index, so choosing index 0 continues the accumulation. An instruction that returns to the processor puts the value on the result port and clears register 0, which leaves it ready for a fresh sequence.

The processor interface is the plain start/done multicycle handshake with a clock enable. It has no valid/ready flow control. The unit takes exactly one instruction at a time, and while one is in flight it gives no back-pressure; it simply ignores further start pulses.

Top module: `mac_ci_unit`

## Requirements
- R1: After synchronous reset, `done` is low, `res_out` is zero, and every private register reads as zero.
- R2: When `use_a_ext` is high, operand A is `opnd_a_in` and `sel_a` has no effect. When it is low, operand A is the private register selected by `sel_a`.
- R3: When `use_b_ext` is high, operand B is `opnd_b_in` and `sel_b` has no effect. When it is low, operand B is the private register selected by `sel_b`.
- R4: The computed value is register 0 plus operand A times operand B, kept to the low 32 bits.
- R5: When `to_host` is low, the computed value is written to the register selected by `sel_c`. With `sel_c` = 0 this continues the accumulation.
- R6: When `to_host` is high, `res_out` carries the computed value while `done` is high, register 0 is cleared, and `sel_c` has no effect: no other register changes.
- R7: A start accepted at an enabled clock edge makes `done` rise after the third enabled edge, counting that edge as the first. `done` stays high for exactly one enabled cycle.
- R8: A start seen while an instruction is pending is ignored. A start is accepted in any enabled cycle with nothing pending, including the cycle in which `done` is high.
- R9: While `clk_en` is low, no state changes. This includes `done`, `res_out` and the private registers.
- R10: The flags, indexes and operands are sampled at the accepting edge. Later changes to them do not affect the instruction in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| reset | input | 1 | Synchronous reset, active high |
| clk_en | input | 1 | Clock enable; all state holds when low |
| start | input | 1 | Instruction start request |
| use_a_ext | input | 1 | Operand A taken from opnd_a_in when high |
| use_b_ext | input | 1 | Operand B taken from opnd_b_in when high |
| to_host | input | 1 | Return value on res_out and clear register 0 when high |
| sel_a | input | 5 | Register index for operand A |
| sel_b | input | 5 | Register index for operand B |
| sel_c | input | 5 | Destination register index |
| opnd_a_in | input | 32 | Processor-supplied operand A |
| opnd_b_in | input | 32 | Processor-supplied operand B |
| done | output | 1 | One-cycle completion pulse |
| res_out | output | 32 | Value returned to the processor |

## Verification
The result of each instruction is due after the third enabled edge, counting the accepting edge as the first. The bench drives a start at a falling edge and then samples `done` at the next three falling edges: low, low, then high, when `res_out` is compared. Clock-enable stalls add their length to this count, and the bench checks `done` as low for each stalled cycle. A value written to a register cannot be seen at the ports directly, so the bench reads it back with a later returning instruction. Because the next start is issued in the done cycle, that read also covers the register write that occurs one edge before.

// File: rtl/mac_ci_pkg.sv
package mac_ci_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_MUL  = 2'd1,
    ST_ADD  = 2'd2
  } mac_state_e;
endpackage

// File: rtl/mac_regfile.sv
module mac_regfile #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int ACC_IDX = 0
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              en,
  input  logic [IDX_W-1:0]  ra_idx,
  input  logic [IDX_W-1:0]  rb_idx,
  input  logic              we,
  input  logic [IDX_W-1:0]  w_idx,
  input  logic [DATA_W-1:0] w_data,
  output logic [DATA_W-1:0] ra_data,
  output logic [DATA_W-1:0] rb_data,
  output logic [DATA_W-1:0] acc_data
);
  localparam int NREGS = 1 << IDX_W;

  logic [DATA_W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (reset) begin
      for (int i = 0; i < NREGS; i++) regs[i] <= '0;
    end else if (en && we) begin
      regs[w_idx] <= w_data;
    end
  end

  assign ra_data  = regs[ra_idx];
  assign rb_data  = regs[rb_idx];
  assign acc_data = regs[ACC_IDX];
endmodule

// File: rtl/mac_ctrl.sv
module mac_ctrl
  import mac_ci_pkg::*;
#(
  parameter int IDX_W = 5
) (
  input  logic             clk,
  input  logic             reset,
  input  logic             en,
  input  logic             start,
  input  logic             to_host_i,
  input  logic [IDX_W-1:0] sel_c_i,
  output logic             cap_o,
  output logic             mul_o,
  output logic             fin_o,
  output logic             busy_o,
  output logic             done_o,
  output logic             host_q_o,
  output logic [IDX_W-1:0] dst_q_o
);
  mac_state_e state_q;

  assign cap_o  = (state_q == ST_IDLE) && start;
  assign mul_o  = (state_q == ST_MUL);
  assign fin_o  = (state_q == ST_ADD);
  assign busy_o = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (reset) begin
      state_q  <= ST_IDLE;
      done_o   <= 1'b0;
      host_q_o <= 1'b0;
      dst_q_o  <= '0;
    end else if (en) begin
      done_o <= fin_o;
      unique case (state_q)
        ST_IDLE: if (start) begin
          state_q  <= ST_MUL;
          host_q_o <= to_host_i;
          dst_q_o  <= sel_c_i;
        end
        ST_MUL:  state_q <= ST_ADD;
        ST_ADD:  state_q <= ST_IDLE;
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mac_datapath.sv
module mac_datapath #(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              en,
  input  logic              cap,
  input  logic              mul,
  input  logic              fin,
  input  logic              ext_a,
  input  logic              ext_b,
  input  logic [DATA_W-1:0] opnd_a_in,
  input  logic [DATA_W-1:0] opnd_b_in,
  input  logic [DATA_W-1:0] rf_a,
  input  logic [DATA_W-1:0] rf_b,
  input  logic [DATA_W-1:0] acc_in,
  output logic [DATA_W-1:0] sum_o,
  output logic [DATA_W-1:0] res_o
);
  logic [DATA_W-1:0] opa_q, opb_q, prod_q;

  assign sum_o = acc_in + prod_q;

  always_ff @(posedge clk) begin
    if (reset) begin
      opa_q  <= '0;
      opb_q  <= '0;
      prod_q <= '0;
      res_o  <= '0;
    end else if (en) begin
      if (cap) begin
        opa_q <= ext_a ? opnd_a_in : rf_a;
        opb_q <= ext_b ? opnd_b_in : rf_b;
      end
      if (mul) prod_q <= opa_q * opb_q;
      if (fin) res_o  <= sum_o;
    end
  end
endmodule

// File: rtl/mac_ci_unit.sv
module mac_ci_unit #(
  parameter int DATA_W  = 32,
  parameter int IDX_W   = 5,
  parameter int ACC_IDX = 0
) (
  input  logic              clk,
  input  logic              reset,
  input  logic              clk_en,
  input  logic              start,
  input  logic              use_a_ext,
  input  logic              use_b_ext,
  input  logic              to_host,
  input  logic [IDX_W-1:0]  sel_a,
  input  logic [IDX_W-1:0]  sel_b,
  input  logic [IDX_W-1:0]  sel_c,
  input  logic [DATA_W-1:0] opnd_a_in,
  input  logic [DATA_W-1:0] opnd_b_in,
  output logic              done,
  output logic [DATA_W-1:0] res_out
);
  localparam logic [IDX_W-1:0] ACC_SEL = IDX_W'(ACC_IDX);

  logic              cap, mul, fin, busy, host_q;
  logic [IDX_W-1:0]  dst_q, wr_idx;
  logic [DATA_W-1:0] rf_a, rf_b, acc_val, sum, wr_data;

  assign wr_idx  = host_q ? ACC_SEL : dst_q;
  assign wr_data = host_q ? '0 : sum;

  mac_ctrl #(.IDX_W(IDX_W)) u_ctrl (
    .clk(clk), .reset(reset), .en(clk_en), .start(start),
    .to_host_i(to_host), .sel_c_i(sel_c),
    .cap_o(cap), .mul_o(mul), .fin_o(fin), .busy_o(busy),
    .done_o(done), .host_q_o(host_q), .dst_q_o(dst_q)
  );

  mac_regfile #(.DATA_W(DATA_W), .IDX_W(IDX_W), .ACC_IDX(ACC_IDX)) u_rf (
    .clk(clk), .reset(reset), .en(clk_en),
    .ra_idx(sel_a), .rb_idx(sel_b),
    .we(fin), .w_idx(wr_idx), .w_data(wr_data),
    .ra_data(rf_a), .rb_data(rf_b), .acc_data(acc_val)
  );

  mac_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk(clk), .reset(reset), .en(clk_en),
    .cap(cap), .mul(mul), .fin(fin),
    .ext_a(use_a_ext), .ext_b(use_b_ext),
    .opnd_a_in(opnd_a_in), .opnd_b_in(opnd_b_in),
    .rf_a(rf_a), .rf_b(rf_b), .acc_in(acc_val),
    .sum_o(sum), .res_o(res_out)
  );
endmodule

// File: rtl/mac_ci_chk.sv
module mac_ci_chk #(
  parameter int DATA_W = 32,
  parameter int IDX_W  = 5
) (
  input logic              clk,
  input logic              reset,
  input logic              clk_en,
  input logic              done,
  input logic [DATA_W-1:0] res_out,
  input logic              busy,
  input logic              host_q,
  input logic [IDX_W-1:0]  dst_q,
  input logic [DATA_W-1:0] acc_val
);
  // R1
  reset_idle_chk: assert property (@(posedge clk) reset |=> !done);

  // R7
  done_single_chk: assert property (@(posedge clk) disable iff (reset)
    (done && clk_en) |=> !done);

  // R9
  frozen_chk: assert property (@(posedge clk) disable iff (reset)
    !clk_en |=> ($stable(done) && $stable(res_out)));

  // R6
  acc_cleared_chk: assert property (@(posedge clk) disable iff (reset)
    (done && host_q) |-> (acc_val == '0));

  // R5
  acc_tracks_chk: assert property (@(posedge clk) disable iff (reset)
    (done && !host_q && dst_q == '0) |-> (acc_val == res_out));

  // R8
  done_after_busy_chk: assert property (@(posedge clk) disable iff (reset)
    $rose(done) |-> $past(busy));
endmodule

bind mac_ci_unit mac_ci_chk #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_chk (
  .clk(clk), .reset(reset), .clk_en(clk_en), .done(done),
  .res_out(res_out), .busy(busy), .host_q(host_q), .dst_q(dst_q),
  .acc_val(acc_val)
);

// File: tb/tb_mac_ci_unit.sv
`timescale 1ns/1ps
module tb_mac_ci_unit;
  logic        clk = 1'b0;
  logic        reset = 1'b1;
  logic        clk_en = 1'b1;
  logic        start = 1'b0;
  logic        use_a_ext = 1'b0, use_b_ext = 1'b0, to_host = 1'b0;
  logic [4:0]  sel_a = '0, sel_b = '0, sel_c = '0;
  logic [31:0] opnd_a_in = '0, opnd_b_in = '0;
  logic        done;
  logic [31:0] res_out;

  logic [31:0] model [32];
  int n_chk = 0;
  int n_err = 0;

  always #2 clk = ~clk;

  mac_ci_unit dut (
    .clk(clk), .reset(reset), .clk_en(clk_en), .start(start),
    .use_a_ext(use_a_ext), .use_b_ext(use_b_ext), .to_host(to_host),
    .sel_a(sel_a), .sel_b(sel_b), .sel_c(sel_c),
    .opnd_a_in(opnd_a_in), .opnd_b_in(opnd_b_in),
    .done(done), .res_out(res_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Called at a falling edge; returns at the falling edge where done is high.
  task automatic run_op(input bit ua, input bit ub, input bit host,
                        input logic [4:0] a, input logic [4:0] b, input logic [4:0] c,
                        input logic [31:0] da, input logic [31:0] db,
                        input int stall, input bit poke, output logic [31:0] got);
    logic [31:0] opa, opb, val;
    opa = ua ? da : model[a];
    opb = ub ? db : model[b];
    val = model[0] + opa * opb;
    use_a_ext = ua; use_b_ext = ub; to_host = host;
    sel_a = a; sel_b = b; sel_c = c; opnd_a_in = da; opnd_b_in = db;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk("R7 done low after accept", {31'd0, done}, 32'd0);
    if (poke) begin
      // R8 / R10: start while pending with every input changed
      start = 1'b1; use_a_ext = ~ua; use_b_ext = ~ub; to_host = ~host;
      sel_a = a ^ 5'd3; sel_b = b ^ 5'd5; sel_c = c ^ 5'd1;
      opnd_a_in = ~da; opnd_b_in = db + 32'd9;
    end
    if (stall > 0) begin
      clk_en = 1'b0;
      for (int s = 0; s < stall; s++) begin
        @(negedge clk);
        chk("R9 done low while stalled", {31'd0, done}, 32'd0);
      end
      clk_en = 1'b1;
    end
    @(negedge clk);
    start = 1'b0;
    chk("R7 done low in second cycle", {31'd0, done}, 32'd0);
    @(negedge clk);
    chk("R7 done high after third edge", {31'd0, done}, 32'd1);
    if (host) chk("R6 R4 returned value", res_out, val);
    if (host) model[0] = '0;
    else model[c] = val;
    got = res_out;
  endtask

  task automatic read_reg(input logic [4:0] i, input string req);
    logic [31:0] g, exp;
    exp = model[0] + model[i];
    run_op(1'b0, 1'b1, 1'b1, i, 5'd0, 5'd0, 32'd0, 32'd1, 0, 1'b0, g);
    chk(req, g, exp);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog expired actual=hung expected=finished");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin
    logic [31:0] g, held;
    for (int i = 0; i < 32; i++) model[i] = '0;
    repeat (4) @(negedge clk);
    chk("R1 done low in reset", {31'd0, done}, 32'd0);
    reset = 1'b0;
    @(negedge clk);
    chk("R1 done low after reset", {31'd0, done}, 32'd0);
    chk("R1 res_out zero after reset", res_out, 32'd0);

    // R1: every register reads zero
    for (int i = 0; i < 32; i++) read_reg(5'(i), "R1 register zero");

    // R5 R4: fill registers 1..31, products large enough to truncate
    for (int i = 1; i < 32; i++)
      run_op(1'b1, 1'b1, 1'b0, 5'd0, 5'd0, 5'(i),
             32'(i) * 32'h0101_0101 + 32'd7, 32'(i) * 32'h0001_0003 + 32'd1, 0, 1'b0, g);
    // R2 register path readback
    for (int i = 1; i < 32; i++) read_reg(5'(i), "R2 R5 register readback");

    // R2: sel_a ignored when use_a_ext high
    for (int i = 1; i < 32; i += 5) begin
      run_op(1'b1, 1'b1, 1'b1, 5'(i), 5'(i), 5'd0, 32'd5, 32'd3, 0, 1'b0, g);
      chk("R2 external A", g, 32'd15);
    end
    // R3: B from register, and sel_b ignored when external
    for (int i = 1; i < 32; i += 3) begin
      run_op(1'b1, 1'b0, 1'b1, 5'd7, 5'(i), 5'd0, 32'd1, 32'd0, 0, 1'b0, g);
      chk("R3 register B", g, model[i]);
    end

    // R4 R5: accumulate products of register pairs into register 0
    for (int i = 1; i < 32; i++)
      run_op(1'b0, 1'b0, 1'b0, 5'(i), 5'(32 - i), 5'd0, 32'd0, 32'd0, 0, 1'b0, g);
    held = model[0];
    run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 32'd0, 32'd0, 0, 1'b0, g);
    chk("R4 accumulated sum", g, held);
    run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 32'd0, 32'd0, 0, 1'b0, g);
    chk("R6 accumulator cleared by return", g, 32'd0);

    // R6: sel_c ignored on return
    held = model[5];
    run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'd5, 32'd11, 32'd13, 0, 1'b0, g);
    read_reg(5'd5, "R6 sel_c ignored on return");
    chk("R6 register 5 unchanged", model[5], held);

    // R8 R10: start while pending, inputs changed mid-flight
    run_op(1'b1, 1'b0, 1'b1, 5'd0, 5'd9, 5'd0, 32'd3, 32'd0, 0, 1'b1, g);
    chk("R8 R10 pending start ignored", g, 32'd3 * model[9]);
    @(negedge clk);
    chk("R8 no second done", {31'd0, done}, 32'd0);

    // R9: stall mid-flight, then stall across the done cycle
    run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 32'd21, 32'd2, 3, 1'b0, g);
    chk("R9 result after stall", g, 32'd42);
    clk_en = 1'b0;
    for (int s = 0; s < 2; s++) begin
      @(negedge clk);
      chk("R9 done held", {31'd0, done}, 32'd1);
      chk("R9 res_out held", res_out, 32'd42);
    end
    clk_en = 1'b1;
    @(negedge clk);
    chk("R7 done drops after one enabled cycle", {31'd0, done}, 32'd0);

    // R4: sweep of small external operands, each returned
    for (int a = 0; a < 16; a++)
      for (int b = 0; b < 16; b++) begin
        run_op(1'b1, 1'b1, 1'b1, 5'd0, 5'd0, 5'd0, 32'(a), 32'(b), 0, 1'b0, g);
        chk("R4 product sweep", g, 32'(a * b));
      end

    @(negedge clk);
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule